// File: doc/BRIEF.md
# PWM Auto-Shutdown With Restart

This block generates four pulse-width-modulated outputs from a shared free-running period counter and guards them with a fault-driven shutdown controller. Outputs A and B carry the duty-cycle pulse. Outputs C and D carry its complement. Polarity is chosen per pair: one bit sets A and C, another sets B and D.

An asynchronous fault level is brought into the clock domain and sets a shutdown status bit. While that bit is set, every output sits at its inactive level.

Recovery has two policies, chosen by a restart-enable bit:

- **Automatic:** the status bit clears by itself as soon as the fault has gone.
- **Software-cleared:** the status bit waits until software writes a zero to it.

Software can also force a shutdown by writing a one. Any write is ignored while the synchronized fault is high.

Once the status bit is clear, the outputs stay quiet until the next period start. The counter keeps running during shutdown, so the restart always lands on a true period edge. A sticky flag marks the start of the second period after enable. This tells software that one complete cycle has been driven.

Top module: `pwm_fault_guard`

## Requirements
- R1: While enabled, the counter steps 0 to PERIOD-1 and wraps. A and B are active while the count is below DUTY, and C and D are active for the remaining counts. A DUTY of 0 never activates A or B. A DUTY at or above PERIOD keeps A and B active for the whole period.
- R2: `pol_ac` sets the polarity of A and C, and `pol_bd` sets the polarity of B and D. The encoding is 0 = active-high and 1 = active-low. The inactive pin level equals the polarity bit.
- R3: After synchronous reset, and while `enable` is low, all four outputs sit at their inactive level. After reset, `shut_stat` and `cycle_done` are 0.
- R4: `fault_in` passes through a two-flop synchronizer. `shut_stat` rises on the third rising edge after `fault_in` is first sampled high. The outputs go inactive on the edge that follows.
- R5: With `restart_en` = 1, `shut_stat` clears by itself on the edge after the synchronized fault is seen low.
- R6: With `restart_en` = 0, `shut_stat` stays set after the fault ends, until software writes 0 (`sw_wr` = 1 with `sw_wdata` = 0).
- R7: A software write of 1 with no fault present sets `shut_stat` on that edge. This forces the outputs inactive.
- R8: A software write to the status bit has no effect while the synchronized fault is high.
- R9: After `shut_stat` clears, the outputs stay inactive until the next period start that comes after the clearing edge. They then resume the normal waveform.
- R10: `cycle_done` sets on the edge where the second period begins after `enable` rises, which is the PERIOD-th edge. It stays set, through shutdowns as well, until `enable` drops.
- R11: The period counter keeps running during shutdown, so the first resumed output matches count 0 of the timeline that started at enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the counter and the outputs |
| period | input | CNT_W | Period length in clocks |
| duty | input | CNT_W | Active count of A/B per period |
| pol_ac | input | 1 | Polarity of A and C (1 = active-low) |
| pol_bd | input | 1 | Polarity of B and D (1 = active-low) |
| restart_en | input | 1 | 1 = automatic recovery, 0 = software clear |
| fault_in | input | 1 | Asynchronous shutdown level |
| sw_wr | input | 1 | Write strobe for the status bit |
| sw_wdata | input | 1 | Value written to the status bit |
| out_a | output | 1 | PWM output A |
| out_b | output | 1 | PWM output B |
| out_c | output | 1 | PWM output C (complement of A) |
| out_d | output | 1 | PWM output D (complement of B) |
| shut_stat | output | 1 | Shutdown status bit |
| cycle_done | output | 1 | First full period completed |

## Verification
Two pairs of functions can meet in the same cycle.

- **Software clear against a live fault:** the bench drives a zero write into the status bit while the synchronized fault is high. It then checks that the bit stays set.
- **Status clear against the period counter:** the bench releases the fault mid-period under automatic restart. It counts clocks on its own timeline from enable and checks that every output stays quiet until count 0 comes round again. The first resumed sample must then be active.

// File: rtl/pwmsd_pkg.sv
package pwmsd_pkg;
  localparam int NUM_OUT = 4;

  // map an "active" request to a pin level under a polarity bit
  function automatic logic pin_level(input logic active, input logic pol);
    return active ^ pol;
  endfunction
endpackage

// File: rtl/pwmsd_sync.sv
module pwmsd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    genvar s;
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= 1'b0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/pwmsd_timebase.sv
module pwmsd_timebase #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap,
  output logic             flag_q
);
  localparam int EXT_W = CNT_W + 1;

  logic [EXT_W-1:0] next_ext;
  assign next_ext = {1'b0, cnt_q} + EXT_W'(1);
  assign wrap     = enable && (next_ext >= {1'b0, period});

  always_ff @(posedge clk) begin
    if (rst || !enable) cnt_q <= '0;
    else if (wrap)      cnt_q <= '0;
    else                cnt_q <= next_ext[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) flag_q <= 1'b0;
    else if (wrap)      flag_q <= 1'b1;
  end

  // R10: the flag can only appear together with a period start
  assert_flag_at_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> (cnt_q == '0));
endmodule

// File: rtl/pwmsd_status.sv
module pwmsd_status (
  input  logic clk,
  input  logic rst,
  input  logic fault_lvl,
  input  logic restart_en,
  input  logic sw_wr,
  input  logic sw_wdata,
  output logic shut_q
);
  always_ff @(posedge clk) begin
    if (rst)             shut_q <= 1'b0;
    else if (fault_lvl)  shut_q <= 1'b1;      // level cause wins, writes ignored
    else if (sw_wr)      shut_q <= sw_wdata;  // clear or force
    else if (restart_en) shut_q <= 1'b0;      // cause gone: auto recovery
  end

  assert_write_blocked_R8: assert property (@(posedge clk) disable iff (rst)
    (fault_lvl && sw_wr) |=> shut_q);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (!restart_en && shut_q && !sw_wr) |=> shut_q);

  assert_autoclear_R5: assert property (@(posedge clk) disable iff (rst)
    (restart_en && shut_q && !fault_lvl && !sw_wr) |=> !shut_q);
endmodule

// File: rtl/pwmsd_drive.sv
module pwmsd_drive
  import pwmsd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               shut,
  input  logic               wrap,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [CNT_W-1:0]   duty,
  input  logic               pol_ac,
  input  logic               pol_bd,
  output logic [NUM_OUT-1:0] out_q
);
  logic gate_q;
  logic below;
  logic run;
  logic [NUM_OUT-1:0] pol_vec;
  logic [NUM_OUT-1:0] act_vec;

  // resume only once a period start follows a clear status
  always_ff @(posedge clk) begin
    if (rst || !enable) gate_q <= 1'b1;
    else if (shut)      gate_q <= 1'b0;
    else if (wrap)      gate_q <= 1'b1;
  end

  assign below   = (cnt < duty);
  assign run     = enable && gate_q && !shut;
  // index 0=A 1=B 2=C 3=D
  assign pol_vec = {pol_bd, pol_ac, pol_bd, pol_ac};
  assign act_vec = {run && !below, run && !below, run && below, run && below};

  generate
    genvar i;
    for (i = 0; i < NUM_OUT; i++) begin : g_pin
      always_ff @(posedge clk) begin
        if (rst) out_q[i] <= pol_vec[i];
        else     out_q[i] <= pin_level(act_vec[i], pol_vec[i]);
      end
    end
  endgenerate

  assert_quiet_in_shutdown_R4: assert property (@(posedge clk) disable iff (rst)
    shut |=> (out_q == $past(pol_vec)));

  assert_resume_on_boundary_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_q) |-> (cnt == '0));
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
  import pwmsd_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty,
  input  logic             pol_ac,
  input  logic             pol_bd,
  input  logic             restart_en,
  input  logic             fault_in,
  input  logic             sw_wr,
  input  logic             sw_wdata,
  output logic             out_a,
  output logic             out_b,
  output logic             out_c,
  output logic             out_d,
  output logic             shut_stat,
  output logic             cycle_done
);
  logic               fault_lvl;
  logic [CNT_W-1:0]   cnt;
  logic               wrap;
  logic [NUM_OUT-1:0] pins;

  pwmsd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(fault_in), .dout(fault_lvl));

  pwmsd_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst(rst), .enable(enable), .period(period),
    .cnt_q(cnt), .wrap(wrap), .flag_q(cycle_done));

  pwmsd_status u_stat (
    .clk(clk), .rst(rst), .fault_lvl(fault_lvl), .restart_en(restart_en),
    .sw_wr(sw_wr), .sw_wdata(sw_wdata), .shut_q(shut_stat));

  pwmsd_drive #(.CNT_W(CNT_W)) u_drv (
    .clk(clk), .rst(rst), .enable(enable), .shut(shut_stat), .wrap(wrap),
    .cnt(cnt), .duty(duty), .pol_ac(pol_ac), .pol_bd(pol_bd), .out_q(pins));

  assign out_a = pins[0];
  assign out_b = pins[1];
  assign out_c = pins[2];
  assign out_d = pins[3];

  // R11: the counter is untouched by the shutdown status
  assert_count_runs_R11: assert property (@(posedge clk) disable iff (rst)
    (enable && $past(enable) && shut_stat && !$past(wrap)) |-> (cnt == $past(cnt) + 1'b1));
endmodule

// File: tb/tb_pwm_fault_guard.sv
module tb_pwm_fault_guard;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic [W-1:0] period = 8'd8;
  logic [W-1:0] duty = 8'd4;
  logic pol_ac = 1'b0, pol_bd = 1'b0;
  logic restart_en = 1'b1, fault_in = 1'b0, sw_wr = 1'b0, sw_wdata = 1'b0;
  logic out_a, out_b, out_c, out_d, shut_stat, cycle_done;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pwm_fault_guard #(.CNT_W(W)) dut (
    .clk(clk), .rst(rst), .enable(enable), .period(period), .duty(duty),
    .pol_ac(pol_ac), .pol_bd(pol_bd), .restart_en(restart_en),
    .fault_in(fault_in), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_d(out_d),
    .shut_stat(shut_stat), .cycle_done(cycle_done));

  typedef struct packed {
    logic [7:0] per;
    logic [7:0] dty;
    logic       pac;
    logic       pbd;
    logic [7:0] ea;
    logic [7:0] eb;
    logic [7:0] ec;
    logic [7:0] ed;
  } vec_t;

  // expected high-sample counts over one period (R1, R2)
  localparam vec_t VECS [5] = '{
    '{8'd8,  8'd3,  1'b0, 1'b0, 8'd3,  8'd3, 8'd5,  8'd5},
    '{8'd8,  8'd0,  1'b1, 1'b0, 8'd8,  8'd0, 8'd0,  8'd8},
    '{8'd5,  8'd5,  1'b0, 1'b1, 8'd5,  8'd0, 8'd0,  8'd5},
    '{8'd10, 8'd12, 1'b1, 1'b1, 8'd0,  8'd0, 8'd10, 8'd10},
    '{8'd6,  8'd2,  1'b0, 1'b1, 8'd2,  8'd4, 8'd4,  8'd2}
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    tick(200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int k;
    int ca, cb, cc, cd;
    int bad_q;
    tick(3);
    rst = 1'b0;
    tick(1);
    // R3 reset state
    chk({out_a, out_b, out_c, out_d} == 4'b0000, "R3 outputs after reset",
        {out_a, out_b, out_c, out_d}, 0);
    chk(shut_stat == 1'b0 && cycle_done == 1'b0, "R3 status/flag after reset",
        {shut_stat, cycle_done}, 0);

    // vector walk: R1 R2
    for (int v = 0; v < 5; v++) begin
      period = VECS[v].per; duty = VECS[v].dty;
      pol_ac = VECS[v].pac; pol_bd = VECS[v].pbd;
      tick(1);
      chk({out_d, out_c, out_b, out_a} == {pol_bd, pol_ac, pol_bd, pol_ac},
          "R3 idle outputs inactive", {out_d, out_c, out_b, out_a},
          {pol_bd, pol_ac, pol_bd, pol_ac});
      enable = 1'b1;
      ca = 0; cb = 0; cc = 0; cd = 0;
      for (int s = 0; s < int'(VECS[v].per); s++) begin
        tick(1);
        ca += out_a; cb += out_b; cc += out_c; cd += out_d;
      end
      chk(ca == int'(VECS[v].ea), "R1 R2 out_a high count", ca, VECS[v].ea);
      chk(cb == int'(VECS[v].eb), "R2 out_b high count", cb, VECS[v].eb);
      chk(cc == int'(VECS[v].ec), "R1 out_c high count", cc, VECS[v].ec);
      chk(cd == int'(VECS[v].ed), "R2 out_d high count", cd, VECS[v].ed);
      enable = 1'b0;
      tick(2);
    end

    // automatic restart, fault timing, write block, resume alignment
    period = 8'd8; duty = 8'd4; pol_ac = 1'b0; pol_bd = 1'b0; restart_en = 1'b1;
    tick(1);
    enable = 1'b1; k = 0;
    tick(3); k = 3;
    chk(out_a == 1'b1, "R1 out_a active in low counts", out_a, 1);
    fault_in = 1'b1;
    tick(2); k = 5;
    chk(shut_stat == 1'b0, "R4 status before sync delay", shut_stat, 0);
    tick(1); k = 6;
    chk(shut_stat == 1'b1, "R4 status after sync delay", shut_stat, 1);
    tick(1); k = 7;
    chk({out_a, out_b, out_c, out_d} == 4'b0000, "R4 outputs quiet in shutdown",
        {out_a, out_b, out_c, out_d}, 0);
    chk(cycle_done == 1'b0, "R10 flag before second period", cycle_done, 0);
    sw_wr = 1'b1; sw_wdata = 1'b0;
    tick(1); k = 8;
    sw_wr = 1'b0;
    chk(shut_stat == 1'b1, "R8 clear write ignored during fault", shut_stat, 1);
    chk(cycle_done == 1'b1, "R10 flag at second period start", cycle_done, 1);
    fault_in = 1'b0;
    tick(2); k = 10;
    chk(shut_stat == 1'b1, "R5 status held while sync drains", shut_stat, 1);
    tick(1); k = 11;
    chk(shut_stat == 1'b0, "R5 auto clear after fault", shut_stat, 0);
    bad_q = 0;
    tick(1); k = 12;
    while (!(((k - 1) % 8) == 0 && k >= 13)) begin
      if ({out_a, out_b, out_c, out_d} != 4'b0000) bad_q++;
      tick(1); k++;
    end
    chk(bad_q == 0, "R9 outputs quiet until period start", bad_q, 0);
    chk(k == 17 && out_a == 1'b1 && out_c == 1'b0, "R9 R11 resume at count 0",
        k * 10 + out_a, 171);
    enable = 1'b0;
    tick(1);
    chk(cycle_done == 1'b0, "R10 flag clears on disable", cycle_done, 0);

    // software-cleared policy with active-low pair, and forced shutdown
    restart_en = 1'b0; pol_ac = 1'b1; pol_bd = 1'b0;
    tick(1);
    enable = 1'b1;
    tick(2);
    fault_in = 1'b1;
    tick(4);
    chk({out_a, out_b, out_c, out_d} == 4'b1010, "R2 inactive levels in shutdown",
        {out_a, out_b, out_c, out_d}, 10);
    fault_in = 1'b0;
    tick(6);
    chk(shut_stat == 1'b1, "R6 status sticky after fault", shut_stat, 1);
    sw_wr = 1'b1; sw_wdata = 1'b0;
    tick(1);
    sw_wr = 1'b0;
    chk(shut_stat == 1'b0, "R6 software clear", shut_stat, 0);
    tick(3);
    sw_wr = 1'b1; sw_wdata = 1'b1;
    tick(1);
    sw_wr = 1'b0;
    chk(shut_stat == 1'b1, "R7 forced shutdown sets status", shut_stat, 1);
    tick(1);
    chk({out_a, out_b, out_c, out_d} == 4'b1010, "R7 forced outputs inactive",
        {out_a, out_b, out_c, out_d}, 10);
    tick(4);
    chk(shut_stat == 1'b1, "R7 forced status holds", shut_stat, 1);
    sw_wr = 1'b1; sw_wdata = 1'b0;
    tick(1);
    sw_wr = 1'b0;
    enable = 1'b0;
    tick(2);
    finish_run();
  end
endmodule